// File: doc/BRIEF.md
# TDM Daisy-Chain Serial Transmitter

This block drives the transmit data line of an audio converter serial port that runs in time-division-multiplexed mode. In each frame it sends four 24-bit sample words, the left and right channels of two stereo converters. Each word goes out most significant bit first and sits at the top of a 32-bit slot. The frame is 8 slots long with a 256x sample-rate bit clock, or 16 slots long with a 512x bit clock.

Several devices can share one receiver port by forming a chain. Each device accepts the serial stream of the device ahead of it on `chain_i` and delays it by four slots, so that stream lands directly behind the device's own four words. The first device in a chain has `chain_i` tied low, so every slot that carries no data reads as zero.

The bit clock and frame clock arrive as plain inputs and are sampled by the system clock `clk`, which must run at least four times faster than the bit clock. The active edge of the bit clock is selectable, and so is the active level of the frame clock. With both polarity inputs at 0 the timing is the usual I2S-style format.

Top module: `tdm_daisy_tx`

## Requirements
- R1: Each slot is 32 bits long and is sent most significant bit first. The 24-bit sample fills slot bits 0 to 23, counted from the start of the slot, and slot bits 24 to 31 are driven as 0.
- R2: The block's own words fill slots 0 to 3 in channel order. Channel k is `samples_i[24k+23:24k]`, with k=0 for left 1, k=1 for right 1, k=2 for left 2 and k=3 for right 2.
- R3: With `wide_i`=0 the frame is 256 bits (8 slots). Slots 4 to 7 carry the `chain_i` stream delayed by exactly 128 bit clocks, so bit p of the upstream frame appears at output position p+128.
- R4: With `wide_i`=1 the frame is 512 bits (16 slots). Slots 4 to 7 carry the delayed chain stream, and slots 8 to 15 are always 0.
- R5: A frame starts at the active bit-clock edge where the frame clock is first seen at its active level. The MSB of slot 0 is driven after the next inactive edge, so a receiver samples it one bit clock after the frame-start edge.
- R6: With `fclk_inv_i`=0 the frame clock is active low, so frames start when it falls (I2S-style). With `fclk_inv_i`=1 it is active high, so frames start when it rises.
- R7: With `bclk_inv_i`=0 the active bit-clock edge is the rising edge; with `bclk_inv_i`=1 it is the falling edge. `tdm_o` changes only after an inactive edge and holds steady across the active edge.
- R8: The four sample words are captured together at frame start. A change to `samples_i` in the middle of a frame has no effect on that frame and appears in the next one.
- R9: After reset, and until the first frame start, `tdm_o` is 0 even while the bit clock runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock |
| bclk_inv_i | input | 1 | 0: rising bit-clock edge is active; 1: falling edge is active |
| fclk_inv_i | input | 1 | 0: frame clock active low; 1: frame clock active high |
| wide_i | input | 1 | 0: 8-slot frame; 1: 16-slot frame |
| samples_i | input | 96 | Four 24-bit words, channel k at bits [24k+23:24k] |
| chain_i | input | 1 | Serial stream from the upstream device (tie to 0 on the first device) |
| tdm_o | output | 1 | Serial TDM output |

## Verification
The bench chains two instances and reads every slot back as a receiver would, by sampling just before each active edge. This catches a chain delay that is one bit too short or too long, which would rotate the upstream words across slot boundaries. It also catches an MSB that is driven on the frame-start edge instead of one bit clock later, which would shift every slot left by one bit. Changing the samples halfway through a frame shows whether the words are latched or read live; a block that reads them live corrupts the second half of its own slots. Runs with both polarity inputs inverted show whether the block ignores either setting: if it does, frames start at the half-frame point or data changes on the edge where the receiver samples.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;

  // Which source feeds a given slot of the outgoing frame.
  typedef enum logic [1:0] {
    SRC_OWN   = 2'd0,
    SRC_CHAIN = 2'd1,
    SRC_EMPTY = 2'd2
  } slot_src_e;

  // Own words come first, then the re-timed chain stream, then silence.
  function automatic slot_src_e slot_source(input int unsigned slot,
                                            input int unsigned own_ch);
    if (slot < own_ch)     return SRC_OWN;
    if (slot < 2 * own_ch) return SRC_CHAIN;
    return SRC_EMPTY;
  endfunction

  // Number of bit clocks in one frame for the selected mode.
  function automatic int unsigned frame_bits(input logic        wide,
                                             input int unsigned narrow_slots,
                                             input int unsigned wide_slots,
                                             input int unsigned slot_bits);
    return (wide ? wide_slots : narrow_slots) * slot_bits;
  endfunction

  // Chain delay: the upstream stream must clear the block's own slots.
  function automatic int unsigned chain_delay(input int unsigned own_ch,
                                              input int unsigned slot_bits);
    return own_ch * slot_bits;
  endfunction

endpackage

// File: rtl/tdm_tx_edges.sv
`timescale 1ns/1ps
module tdm_tx_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic bclk_inv_i,
  input  logic fclk_inv_i,
  output logic act_edge_o,
  output logic inact_edge_o,
  output logic frame_start_o
);

  logic bclk_lvl;     // bit clock normalised so that a rise is the active edge
  logic bclk_lvl_q;
  logic fr_active;    // frame clock at its active level
  logic fr_active_q;  // frame clock level seen at the previous active edge

  assign bclk_lvl  = bclk_i ^ bclk_inv_i;
  assign fr_active = ~(fclk_i ^ fclk_inv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_lvl_q  <= 1'b0;
      fr_active_q <= 1'b1;  // no frame start until a real transition is seen
    end else begin
      bclk_lvl_q <= bclk_lvl;
      if (act_edge_o) fr_active_q <= fr_active;
    end
  end

  assign act_edge_o    = bclk_lvl & ~bclk_lvl_q;
  assign inact_edge_o  = ~bclk_lvl & bclk_lvl_q;
  assign frame_start_o = act_edge_o & fr_active & ~fr_active_q;

endmodule

// File: rtl/tdm_tx_counter.sv
`timescale 1ns/1ps
module tdm_tx_counter
  import tdm_tx_pkg::*;
#(
  parameter int unsigned SLOT_BITS    = 32,
  parameter int unsigned NARROW_SLOTS = 8,
  parameter int unsigned WIDE_SLOTS   = 16,
  parameter int unsigned POS_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_edge_i,
  input  logic             frame_start_i,
  input  logic             wide_i,
  output logic [POS_W-1:0] pos_o,
  output logic             framed_o
);

  logic [POS_W-1:0] pos_q;
  logic             framed_q;
  logic             at_last;

  always_comb begin
    at_last = (32'(pos_q) + 32'd1) >= frame_bits(wide_i, NARROW_SLOTS, WIDE_SLOTS, SLOT_BITS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      framed_q <= 1'b0;
    end else if (act_edge_i) begin
      if (frame_start_i) begin
        pos_q    <= '0;
        framed_q <= 1'b1;
      end else if (at_last) begin
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos_o    = pos_q;
  assign framed_o = framed_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (pos_o == '0) && framed_o); // R5

endmodule

// File: rtl/tdm_tx_delay.sv
`timescale 1ns/1ps
module tdm_tx_delay #(
  parameter int unsigned DEPTH = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_i,
  input  logic din_i,
  output logic tap_o
);

  logic [DEPTH-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (shift_i) line_q <= {line_q[DEPTH-2:0], din_i};
  end

  // A bit captured at active edge k leaves the last stage DEPTH-1 edges
  // later, which is the inactive edge where it must be driven.
  assign tap_o = line_q[DEPTH-1];

endmodule

// File: rtl/tdm_daisy_tx.sv
`timescale 1ns/1ps
module tdm_daisy_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_BITS  = 24,
  parameter int unsigned SLOT_BITS    = 32,
  parameter int unsigned OWN_CH       = 4,
  parameter int unsigned NARROW_SLOTS = 8,
  parameter int unsigned WIDE_SLOTS   = 16,
  localparam int unsigned WORD_VEC    = OWN_CH * SAMPLE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                fclk_i,
  input  logic                bclk_inv_i,
  input  logic                fclk_inv_i,
  input  logic                wide_i,
  input  logic [WORD_VEC-1:0] samples_i,
  input  logic                chain_i,
  output logic                tdm_o
);

  localparam int unsigned FRAME_MAX = WIDE_SLOTS * SLOT_BITS;
  localparam int unsigned POS_W     = $clog2(FRAME_MAX);
  localparam int unsigned BIT_W     = $clog2(SLOT_BITS);
  localparam int unsigned SLOT_W    = POS_W - BIT_W;
  localparam int unsigned CH_W      = (OWN_CH > 1) ? $clog2(OWN_CH) : 1;
  localparam int unsigned DLY_BITS  = chain_delay(OWN_CH, SLOT_BITS);

  // Named internal events, shared with the assertions.
  logic             act_edge;
  logic             inact_edge;
  logic             frame_start;
  logic             framed;
  logic [POS_W-1:0] pos;
  logic             chain_tap;

  tdm_tx_edges u_edges (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk_i),
    .fclk_i       (fclk_i),
    .bclk_inv_i   (bclk_inv_i),
    .fclk_inv_i   (fclk_inv_i),
    .act_edge_o   (act_edge),
    .inact_edge_o (inact_edge),
    .frame_start_o(frame_start)
  );

  tdm_tx_counter #(
    .SLOT_BITS   (SLOT_BITS),
    .NARROW_SLOTS(NARROW_SLOTS),
    .WIDE_SLOTS  (WIDE_SLOTS),
    .POS_W       (POS_W)
  ) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_edge_i   (act_edge),
    .frame_start_i(frame_start),
    .wide_i       (wide_i),
    .pos_o        (pos),
    .framed_o     (framed)
  );

  tdm_tx_delay #(
    .DEPTH(DLY_BITS)
  ) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_i(act_edge),
    .din_i  (chain_i),
    .tap_o  (chain_tap)
  );

  // Sample words, captured together at frame start.
  logic [SAMPLE_BITS-1:0] word_q [OWN_CH];

  for (genvar ch = 0; ch < OWN_CH; ch++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q[ch] <= '0;
      else if (frame_start) word_q[ch] <= samples_i[ch*SAMPLE_BITS +: SAMPLE_BITS];
    end
  end

  // Slot and bit position of the bit that goes out next.
  logic [SLOT_W-1:0]      slot;
  logic [BIT_W-1:0]       bidx;
  logic [CH_W-1:0]        ch_sel;
  slot_src_e              src;
  logic [SAMPLE_BITS-1:0] shifted;
  logic                   nxt_bit;

  assign slot   = pos[POS_W-1:BIT_W];
  assign bidx   = pos[BIT_W-1:0];
  assign ch_sel = slot[CH_W-1:0];
  assign src    = slot_source(32'(slot), OWN_CH);

  always_comb begin
    // Shifting left pushes the addressed bit to the top; positions at or
    // past SAMPLE_BITS shift everything out and yield the zero padding.
    shifted = word_q[ch_sel] << bidx;
    unique case (src)
      SRC_OWN:   nxt_bit = shifted[SAMPLE_BITS-1];
      SRC_CHAIN: nxt_bit = chain_tap;
      default:   nxt_bit = 1'b0;
    endcase
  end

  logic tdm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tdm_q <= 1'b0;
    else if (inact_edge) tdm_q <= framed ? nxt_bit : 1'b0;
  end

  assign tdm_o = tdm_q;

  AST_OUT_ON_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdm_o) |-> $past(inact_edge)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |-> !tdm_o); // R9

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (framed && inact_edge && src == SRC_OWN && 32'(bidx) >= SAMPLE_BITS) |=> !tdm_o); // R1

  AST_WIDE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (framed && inact_edge && src == SRC_EMPTY) |=> !tdm_o); // R4

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(word_q[0]) && $stable(word_q[OWN_CH-1])); // R8

endmodule

// File: tb/tdm_daisy_tx_bench.sv
`timescale 1ns/1ps
module tdm_daisy_tx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fclk = 1'b1;
  logic        bclk_inv = 1'b0;
  logic        fclk_inv = 1'b0;
  logic        wide = 1'b0;
  logic [95:0] smp_d = '0;
  logic [95:0] smp_u = '0;
  logic        up_out;
  logic        dn_out;

  int checks = 0;
  int failures = 0;

  logic cap_d [0:511];
  logic cap_u [0:511];

  always #4 clk = ~clk;

  // Upstream device: first in the chain, its chain input grounded.
  tdm_daisy_tx u_upstream (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk),
    .bclk_inv_i(bclk_inv), .fclk_inv_i(fclk_inv), .wide_i(wide),
    .samples_i(smp_u), .chain_i(1'b0), .tdm_o(up_out)
  );

  // Device under test: last in the chain.
  tdm_daisy_tx u_tdm_daisy_tx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk),
    .bclk_inv_i(bclk_inv), .fclk_inv_i(fclk_inv), .wide_i(wide),
    .samples_i(smp_d), .chain_i(up_out), .tdm_o(dn_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive the pins from logical levels: act=1 means bit clock at active level.
  task automatic drive_pins(input bit act, input bit fr_act);
    bclk = act ^ bclk_inv;
    fclk = ~fr_act ^ fclk_inv;
  endtask

  // One bit period. Captures the line just before the active edge; that
  // bit was driven after the previous inactive edge (position i-1).
  task automatic bit_step(input int i, input int n);
    bit fa;
    fa = (i < n / 2);
    @(negedge clk); drive_pins(1'b0, fa);
    repeat (2) @(negedge clk);
    if (i > 0) begin
      cap_d[i-1] = dn_out;
      cap_u[i-1] = up_out;
    end
    drive_pins(1'b1, fa);
    repeat (2) @(negedge clk);
    drive_pins(1'b0, fa);
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_steps(input int cnt);
    for (int k = 0; k < cnt; k++) bit_step(1000 + k, 2);
  endtask

  function automatic logic [31:0] own_slot(input logic [95:0] w, input int ch);
    return {w[ch*24 +: 24], 8'h00};
  endfunction

  function automatic logic [31:0] exp_down(input int s, input logic [95:0] d,
                                          input logic [95:0] u);
    if (s < 4) return own_slot(d, s);
    if (s < 8) return own_slot(u, s - 4);
    return 32'h0;
  endfunction

  task automatic check_frame(input int n, input logic [95:0] d,
                             input logic [95:0] u, input string scen);
    for (int s = 0; s < n / 32; s++) begin
      logic [31:0] gd, gu, ed, eu;
      for (int b = 0; b < 32; b++) begin
        gd[31-b] = cap_d[s*32 + b];
        gu[31-b] = cap_u[s*32 + b];
      end
      ed = exp_down(s, d, u);
      eu = (s < 4) ? own_slot(u, s) : 32'h0;
      if (s < 4)      chk(gd == ed, "R1/R2/R5", $sformatf("%s down slot %0d", scen, s), gd, ed);
      else if (s < 8) chk(gd == ed, "R3", $sformatf("%s down chained slot %0d", scen, s), gd, ed);
      else            chk(gd == ed, "R4", $sformatf("%s down empty slot %0d", scen, s), gd, ed);
      chk(gu == eu, (s < 4) ? "R2" : "R3", $sformatf("%s upstream slot %0d", scen, s), gu, eu);
    end
  endtask

  // One frame; optionally replaces the samples halfway through it.
  task automatic run_frame(input int n, input logic [95:0] d, input logic [95:0] u,
                           input bit mid, input logic [95:0] d2,
                           input logic [95:0] u2, input string scen);
    smp_d = d;
    smp_u = u;
    for (int i = 0; i <= n; i++) begin
      if (mid && i == n / 2) begin
        smp_d = d2;
        smp_u = u2;
      end
      bit_step(i, n);
    end
    check_frame(n, d, u, scen);
  endtask

  task automatic set_mode(input bit w, input bit bi, input bit fi);
    @(negedge clk);
    wide = w;
    bclk_inv = bi;
    fclk_inv = fi;
    drive_pins(1'b0, 1'b0);
    idle_steps(4);
  endtask

  task automatic test_reset;
    chk(dn_out == 1'b0, "R9", "down output in reset", 32'(dn_out), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dn_out == 1'b0 && up_out == 1'b0, "R9", "outputs after reset",
        {30'h0, dn_out, up_out}, 32'h0);
    // Bit clock runs with the frame clock held inactive: no frame yet.
    for (int k = 0; k < 8; k++) begin
      bit_step(1 + k, 2);
      chk(cap_d[k] == 1'b0 && cap_u[k] == 1'b0, "R9",
          $sformatf("idle bit %0d", k), {30'h0, cap_d[k], cap_u[k]}, 32'h0);
    end
  endtask

  task automatic test_narrow;
    set_mode(1'b0, 1'b0, 1'b0);
    run_frame(256, 96'h123456_abcdef_fedcba_654321, 96'h800001_7ffffe_c3a5f0_0f5a3c,
              1'b0, '0, '0, "narrow A");
    run_frame(256, 96'hffffff_000000_a5a5a5_5a5a5a, 96'h010203_040506_070809_0a0b0c,
              1'b0, '0, '0, "narrow B");
  endtask

  task automatic test_mid_change;
    logic [95:0] d1, u1, d2, u2;
    d1 = 96'h111111_222222_333333_444444;
    u1 = 96'h555555_666666_777777_888888;
    d2 = 96'h9abcde_f01234_56789a_bcdef0;
    u2 = 96'hfedcba_987654_321fed_cba987;
    set_mode(1'b0, 1'b0, 1'b0);
    // R8: the changed samples must not reach the current frame.
    run_frame(256, d1, u1, 1'b1, d2, u2, "R8 mid-change");
    run_frame(256, d2, u2, 1'b0, '0, '0, "R8 next frame");
  endtask

  task automatic test_wide;
    set_mode(1'b1, 1'b0, 1'b0);
    run_frame(512, 96'hdeadbe_efcafe_0badf0_0d1e55, 96'hc0ffee_123abc_fa11ed_b0b0b0,
              1'b0, '0, '0, "R4 wide A");
    run_frame(512, 96'hffffff_ffffff_ffffff_ffffff, 96'hffffff_ffffff_ffffff_ffffff,
              1'b0, '0, '0, "R4 wide ones");
  endtask

  task automatic test_polarity;
    // R6 and R7: inverted frame clock and bit clock.
    set_mode(1'b0, 1'b1, 1'b1);
    run_frame(256, 96'h13579b_2468ac_fdb975_eca864, 96'h0f0f0f_f0f0f0_3c3c3c_c3c3c3,
              1'b0, '0, '0, "R6/R7 both inverted");
    set_mode(1'b0, 1'b1, 1'b0);
    run_frame(256, 96'h765432_10fedc_ba9876_543210, 96'h8a8a8a_5b5b5b_2c2c2c_d1d1d1,
              1'b0, '0, '0, "R7 bit clock inverted");
    set_mode(1'b0, 1'b0, 1'b1);
    run_frame(256, 96'h000001_800000_000000_ffffff, 96'h7e7e7e_818181_000000_abcdef,
              1'b0, '0, '0, "R6 frame clock inverted");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    test_reset();
    test_narrow();
    test_mid_change();
    test_wide();
    test_polarity();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule